// File: doc/BRIEF.md
# Programmable Bus Waveform Engine

This block generates the strobe and control waveforms of an external parallel bus from a small table of interval descriptors. Software fills the table one byte at a time while the engine is idle, then starts a run. During a run the engine walks the intervals, and the same descriptors can drive many different device protocols. Each interval either holds the control outputs for a programmed number of clocks or tests a ready condition every clock and branches. Two ready sources are combined for each test. A source can be a device ready pin, a selected endpoint FIFO flag, or a processor-controlled ready bit.

Interval opcode bits move 16-bit words without processor help. An interval can take a word from the outbound stream and drive it onto the bus, or capture a bus word into the inbound stream. It can also step the bus address. One full pass through the table is a transaction, and a run repeats the transaction a programmed number of times.

Both streams follow valid/ready rules:
- Outbound stream: `wr_ready` depends only on engine state and never on `wr_valid`. A word moves on a clock where both are high. An interval that consumes a word does not end until a word is offered.
- Inbound stream: once `rd_valid` is raised, it stays high with `rd_data` and `rd_last` stable until `rd_ready` is seen. A capturing interval cannot end while that slot is still occupied, so the inbound stream applies back-pressure to the bus waveform.

Top module: `wavegen_engine`

## Requirements
- R1: After reset, `busy`, `done`, `bus_oe`, `wr_ready` and `rd_valid` are 0, and `ctl_out` and `addr_out` are 0. While `busy` is 0, `ctl_out` is 0 and `bus_oe` and `wr_ready` stay low.
- R2: A `go` sampled while idle starts a run on the next clock at interval 0, with `addr_out` loaded from `go_addr` and `done` cleared. A `go` sampled while busy has no effect.
- R3: The descriptor table holds 7 intervals of 4 bytes each, with interval i at byte address 4i. The bytes are: opcode at +0, outputs at +1 (bits 5:0 are `ctl_out`), argument at +2, and logic at +3. A delay interval (opcode bit 0 = 0) drives its outputs for argument+1 clocks (1 to 256) and then moves to interval i+1. Interval number 7 is the end marker.
- R4: A decision interval (opcode bit 0 = 1) lasts one clock per evaluation. It branches to argument bits 2:0 when its condition is true and to bits 5:3 when it is false. The logic byte selects source A in bits 2:0 and source B in bits 5:3. Its bits 7:6 pick the combine function: 0 gives A AND B, 1 gives A OR B, 2 gives A XOR B, and 3 gives A alone.
- R5: Source codes 0 to 5 are `rdy_in[0..5]`, code 7 is `cpu_rdy`, and code 6 is the FIFO flag of endpoint `ep_sel`. That endpoint's 2-bit field in `flag_mode` (bits 2e+1:2e) picks the flag: 0 programmable-level, 1 empty, 2 full, 3 constant 0.
- R6: Reaching interval 7 takes one clock. If further transactions remain, the engine restarts at interval 0. Otherwise `busy` falls and `done` rises and stays high until the next start. `go_count` gives the number of transactions, and 0 means 65536.
- R7: Leaving an interval whose opcode bit 4 is set increments `addr_out` (modulo 512). At no other time does `addr_out` change, except at a start.
- R8: Opcode bit 1 drives `bus_oe`. With opcode bit 3 set, `wr_ready` rises once the interval's timer has expired. The interval waits for `wr_valid`, and the accepted `wr_data` appears on `bus_dout` on the next clock.
- R9: With opcode bit 2 set, leaving the interval captures `bus_din` into `rd_data` and raises `rd_valid`. `rd_last` is set to opcode bit 5 for the trailing check word. The interval cannot end while `rd_valid` is still high.
- R10: Writes on the table port are ignored while `busy` is 1 and at addresses 28 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table byte write strobe |
| cfg_addr | input | 5 | Table byte address |
| cfg_wdata | input | 8 | Table byte value |
| go | input | 1 | Start a run |
| go_count | input | 16 | Transactions per run (0 = 65536) |
| go_addr | input | 9 | Starting bus address |
| cpu_rdy | input | 1 | Processor-driven ready bit (source 7) |
| rdy_in | input | 6 | Device ready inputs (sources 0 to 5) |
| ep_sel | input | 2 | Endpoint whose flag is source 6 |
| flag_mode | input | 8 | Per-endpoint flag choice, 2 bits each |
| ep_empty | input | 4 | Endpoint empty flags |
| ep_full | input | 4 | Endpoint full flags |
| ep_prog | input | 4 | Endpoint programmable-level flags |
| ctl_out | output | 6 | Bus control outputs |
| addr_out | output | 9 | Bus address |
| bus_din | input | 16 | Data read from the bus |
| bus_dout | output | 16 | Data driven to the bus |
| bus_oe | output | 1 | Data output enable |
| wr_valid | input | 1 | Outbound word offered |
| wr_ready | output | 1 | Outbound word accepted |
| wr_data | input | 16 | Outbound word |
| rd_valid | output | 1 | Inbound word present |
| rd_ready | input | 1 | Inbound word taken |
| rd_data | output | 16 | Inbound word |
| rd_last | output | 1 | Inbound word is the trailing check word |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |

## Verification
The bench drives the inbound stream with random back-pressure. A design that let a capture overwrite an unread word would show `rd_data` changing under a held `rd_valid`. Outbound words arrive with gaps, which exposes an engine that ends a consuming interval without a word or latches stale data. Every combine function and every flag choice is tried with inputs that separate them, so a swapped code or a wrong endpoint field sends the branch to the wrong interval. The count of 0 is run to its full 65536 transactions, and a count of 1 is run as well, to catch off-by-one and wrap errors in the repeat counter. Table writes and a second `go` during a run must leave the waveform unchanged.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;
  // opcode byte bit positions
  localparam int OP_DECIDE = 0;
  localparam int OP_OE     = 1;
  localparam int OP_CAP    = 2;
  localparam int OP_POP    = 3;
  localparam int OP_INC    = 4;
  localparam int OP_TAIL   = 5;

  typedef enum logic [1:0] {
    CMB_AND  = 2'd0,
    CMB_OR   = 2'd1,
    CMB_XOR  = 2'd2,
    CMB_PASS = 2'd3
  } combine_e;

  typedef enum logic [1:0] {
    FLG_PROG  = 2'd0,
    FLG_EMPTY = 2'd1,
    FLG_FULL  = 2'd2,
    FLG_OFF   = 2'd3
  } flag_e;

  typedef struct packed {
    logic [7:0] lgc;
    logic [7:0] arg;
    logic [7:0] outs;
    logic [7:0] op;
  } interval_t;
endpackage

// File: rtl/wavegen_desc_ram.sv
module wavegen_desc_ram
  import wavegen_pkg::*;
#(
  parameter int N_INT = 7,
  localparam int IDX_W = $clog2(N_INT + 1),
  localparam int NBYTES = 4 * N_INT,
  localparam int CFG_AW = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [IDX_W-1:0]  cur_idx,
  output interval_t         cur_iv
);
  logic [7:0] mem [NBYTES];
  logic       we_ok;

  assign we_ok = cfg_we && !lock;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else if (we_ok && cfg_addr == CFG_AW'(g)) mem[g] <= cfg_wdata;
    end
  end

  always_comb begin
    cur_iv = '0;
    for (int i = 0; i < N_INT; i++) begin
      if (cur_idx == IDX_W'(i)) begin
        cur_iv = {mem[4*i+3], mem[4*i+2], mem[4*i+1], mem[4*i]};
      end
    end
  end
endmodule

// File: rtl/wavegen_ready_mux.sv
module wavegen_ready_mux
  import wavegen_pkg::*;
#(
  parameter int RDY_W  = 6,
  parameter int NUM_EP = 4,
  localparam int EP_W  = $clog2(NUM_EP),
  localparam int NSRC  = RDY_W + 2
) (
  input  logic [RDY_W-1:0]    rdy_in,
  input  logic                cpu_rdy,
  input  logic [EP_W-1:0]     ep_sel,
  input  logic [2*NUM_EP-1:0] flag_mode,
  input  logic [NUM_EP-1:0]   ep_empty,
  input  logic [NUM_EP-1:0]   ep_full,
  input  logic [NUM_EP-1:0]   ep_prog,
  input  logic [7:0]          lgc,
  output logic                cond
);
  logic            fifo_flag;
  logic [NSRC-1:0] src;
  logic            a_val, b_val;
  flag_e           mode;
  combine_e        fn;

  always_comb begin
    mode      = FLG_OFF;
    fifo_flag = 1'b0;
    for (int e = 0; e < NUM_EP; e++) begin
      if (ep_sel == EP_W'(e)) begin
        mode = flag_e'(flag_mode[2*e +: 2]);
        unique case (mode)
          FLG_PROG:  fifo_flag = ep_prog[e];
          FLG_EMPTY: fifo_flag = ep_empty[e];
          FLG_FULL:  fifo_flag = ep_full[e];
          default:   fifo_flag = 1'b0;
        endcase
      end
    end
  end

  assign src = {cpu_rdy, fifo_flag, rdy_in};

  always_comb begin
    a_val = 1'b0;
    b_val = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (lgc[2:0] == 3'(k)) a_val = src[k];
      if (lgc[5:3] == 3'(k)) b_val = src[k];
    end
  end

  assign fn = combine_e'(lgc[7:6]);

  always_comb begin
    unique case (fn)
      CMB_AND: cond = a_val & b_val;
      CMB_OR:  cond = a_val | b_val;
      CMB_XOR: cond = a_val ^ b_val;
      default: cond = a_val;
    endcase
  end
endmodule

// File: rtl/wavegen_seq.sv
module wavegen_seq
  import wavegen_pkg::*;
#(
  parameter int CTL_W  = 6,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int N_INT  = 7,
  localparam int IDX_W = $clog2(N_INT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CNT_W-1:0]  go_count,
  input  logic [ADDR_W-1:0] go_addr,
  input  interval_t         cur_iv,
  input  logic              cond,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ready,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              busy,
  output logic              done,
  output logic [CTL_W-1:0]  ctl_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(N_INT);

  logic [7:0]       tick;
  logic [CNT_W-1:0] remain;
  logic             active, decide, timer_ok, slot_ok, leave;
  logic [IDX_W-1:0] tgt_raw, target;
  logic             unused_bits;

  assign unused_bits = ^{cur_iv.lgc, cur_iv.op[7:6], cur_iv.outs};

  assign active   = busy && (cur_idx != IDX_END);
  assign decide   = cur_iv.op[OP_DECIDE];
  assign timer_ok = decide || (tick == cur_iv.arg);
  assign slot_ok  = !cur_iv.op[OP_CAP] || !rd_valid;
  assign leave    = active && timer_ok && slot_ok && (!cur_iv.op[OP_POP] || wr_valid);
  assign wr_ready = active && cur_iv.op[OP_POP] && timer_ok && slot_ok;
  assign bus_oe   = active && cur_iv.op[OP_OE];
  assign ctl_out  = active ? cur_iv.outs[CTL_W-1:0] : '0;

  always_comb begin
    if (decide) tgt_raw = cond ? IDX_W'(cur_iv.arg[2:0]) : IDX_W'(cur_iv.arg[5:3]);
    else        tgt_raw = IDX_W'(cur_idx + 1'b1);
    target = (tgt_raw > IDX_END) ? IDX_END : tgt_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx  <= IDX_END;
      tick     <= '0;
      remain   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      addr_out <= '0;
      bus_dout <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_last  <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy     <= 1'b1;
          done     <= 1'b0;
          cur_idx  <= '0;
          tick     <= '0;
          remain   <= go_count - 1'b1;
          addr_out <= go_addr;
        end
      end else if (cur_idx == IDX_END) begin
        if (remain == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          remain  <= remain - 1'b1;
          cur_idx <= '0;
          tick    <= '0;
        end
      end else if (leave) begin
        cur_idx <= target;
        tick    <= '0;
        if (cur_iv.op[OP_INC]) addr_out <= addr_out + 1'b1;
        if (cur_iv.op[OP_POP]) bus_dout <= wr_data;
        if (cur_iv.op[OP_CAP]) begin
          rd_valid <= 1'b1;
          rd_data  <= bus_din;
          rd_last  <= cur_iv.op[OP_TAIL];
        end
      end else if (!timer_ok) begin
        tick <= tick + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wavegen_engine.sv
module wavegen_engine
  import wavegen_pkg::*;
#(
  parameter int CTL_W  = 6,
  parameter int RDY_W  = 6,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int NUM_EP = 4,
  parameter int N_INT  = 7,
  localparam int CFG_AW = $clog2(4 * N_INT),
  localparam int EP_W   = $clog2(NUM_EP)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [7:0]          cfg_wdata,
  input  logic                go,
  input  logic [CNT_W-1:0]    go_count,
  input  logic [ADDR_W-1:0]   go_addr,
  input  logic                cpu_rdy,
  input  logic [RDY_W-1:0]    rdy_in,
  input  logic [EP_W-1:0]     ep_sel,
  input  logic [2*NUM_EP-1:0] flag_mode,
  input  logic [NUM_EP-1:0]   ep_empty,
  input  logic [NUM_EP-1:0]   ep_full,
  input  logic [NUM_EP-1:0]   ep_prog,
  output logic [CTL_W-1:0]    ctl_out,
  output logic [ADDR_W-1:0]   addr_out,
  input  logic [DATA_W-1:0]   bus_din,
  output logic [DATA_W-1:0]   bus_dout,
  output logic                bus_oe,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_last,
  output logic                busy,
  output logic                done
);
  localparam int IDX_W = $clog2(N_INT + 1);

  interval_t        cur_iv;
  logic [IDX_W-1:0] cur_idx;
  logic             cond;

  wavegen_desc_ram #(.N_INT(N_INT)) u_ram (
    .clk(clk), .rst_n(rst_n), .lock(busy), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cur_idx(cur_idx), .cur_iv(cur_iv)
  );

  wavegen_ready_mux #(.RDY_W(RDY_W), .NUM_EP(NUM_EP)) u_mux (
    .rdy_in(rdy_in), .cpu_rdy(cpu_rdy), .ep_sel(ep_sel), .flag_mode(flag_mode),
    .ep_empty(ep_empty), .ep_full(ep_full), .ep_prog(ep_prog),
    .lgc(cur_iv.lgc), .cond(cond)
  );

  wavegen_seq #(
    .CTL_W(CTL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .N_INT(N_INT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .go_count(go_count), .go_addr(go_addr),
    .cur_iv(cur_iv), .cond(cond), .bus_din(bus_din), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_ready(rd_ready), .cur_idx(cur_idx), .busy(busy),
    .done(done), .ctl_out(ctl_out), .addr_out(addr_out), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last)
  );
endmodule

// File: rtl/wavegen_engine_chk.sv
module wavegen_engine_chk #(
  parameter int CTL_W  = 6,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic [ADDR_W-1:0] go_addr,
  input logic              busy,
  input logic              done,
  input logic [CTL_W-1:0]  ctl_out,
  input logic              bus_oe,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] addr_out,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_last
);
  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ctl_out == '0 && !bus_oe && !wr_ready));

  assert_start_loads_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go) |=> (busy && addr_out == $past(go_addr)));

  assert_done_excludes_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_addr_frozen_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> $stable(addr_out));

  assert_wr_ready_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (busy && !done));

  assert_rd_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));
endmodule

bind wavegen_engine wavegen_engine_chk #(
  .CTL_W(CTL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr), .busy(busy), .done(done),
  .ctl_out(ctl_out), .bus_oe(bus_oe), .wr_ready(wr_ready), .addr_out(addr_out),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last)
);

// File: tb/wavegen_engine_bench.sv
module wavegen_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        go = 1'b0;
  logic [15:0] go_count = '0;
  logic [8:0]  go_addr = '0;
  logic        cpu_rdy = 1'b0;
  logic [5:0]  rdy_in = '0;
  logic [1:0]  ep_sel = '0;
  logic [7:0]  flag_mode = '0;
  logic [3:0]  ep_empty = '0, ep_full = '0, ep_prog = '0;
  logic [15:0] bus_din = '0, wr_data = '0;
  logic        wr_valid = 1'b0, rd_ready = 1'b0;
  logic [5:0]  ctl_out;
  logic [8:0]  addr_out;
  logic [15:0] bus_dout, rd_data;
  logic        bus_oe, wr_ready, rd_valid, rd_last, busy, done;

  wavegen_engine u_wavegen_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .go(go), .go_count(go_count), .go_addr(go_addr), .cpu_rdy(cpu_rdy), .rdy_in(rdy_in),
    .ep_sel(ep_sel), .flag_mode(flag_mode), .ep_empty(ep_empty), .ep_full(ep_full),
    .ep_prog(ep_prog), .ctl_out(ctl_out), .addr_out(addr_out), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_last(rd_last), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;
  bit rand_en = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [7:0] m_desc [28];
  int m_cur, m_tick, m_rem, m_addr, m_dout, m_rdd;
  bit m_busy, m_done, m_rdv, m_rdl;

  function automatic bit msrc(int k);
    int mode;
    if (k < 6) return rdy_in[k];
    if (k == 7) return cpu_rdy;
    mode = (flag_mode >> (2 * ep_sel)) & 3;
    case (mode)
      0: return ep_prog[ep_sel];
      1: return ep_empty[ep_sel];
      2: return ep_full[ep_sel];
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : ref_model
    int op, arg, lg, nxt, fn;
    bit dec, tok, sok, ca, cb, cond, old_rdv, was_busy;
    if (!rst_n) begin
      foreach (m_desc[i]) m_desc[i] = '0;
      m_cur = 7; m_tick = 0; m_rem = 0; m_addr = 0; m_dout = 0; m_rdd = 0;
      m_busy = 0; m_done = 0; m_rdv = 0; m_rdl = 0;
    end else begin
      old_rdv = m_rdv;
      was_busy = m_busy;
      if (m_rdv && rd_ready) m_rdv = 0;
      if (!m_busy) begin
        if (go) begin
          m_busy = 1; m_done = 0; m_cur = 0; m_tick = 0;
          m_rem = (go_count == 0) ? 65536 : int'(go_count);
          m_addr = go_addr;
        end
      end else if (m_cur == 7) begin
        m_rem--;
        if (m_rem == 0) begin m_busy = 0; m_done = 1; end
        else begin m_cur = 0; m_tick = 0; end
      end else begin
        op = m_desc[4*m_cur]; arg = m_desc[4*m_cur+2]; lg = m_desc[4*m_cur+3];
        dec = op[0];
        tok = dec || (m_tick == arg);
        sok = !op[2] || !old_rdv;
        if (tok && sok && (!op[3] || wr_valid)) begin
          if (dec) begin
            ca = msrc(lg & 7); cb = msrc((lg >> 3) & 7); fn = (lg >> 6) & 3;
            cond = (fn == 0) ? (ca & cb) : (fn == 1) ? (ca | cb) : (fn == 2) ? (ca ^ cb) : ca;
            nxt = cond ? (arg & 7) : ((arg >> 3) & 7);
          end else nxt = m_cur + 1;
          if (op[4]) m_addr = (m_addr + 1) % 512;
          if (op[3]) m_dout = wr_data;
          if (op[2]) begin m_rdv = 1; m_rdd = bus_din; m_rdl = op[5]; end
          m_cur = nxt; m_tick = 0;
        end else if (!tok) m_tick++;
      end
      if (cfg_we && !was_busy && cfg_addr < 28) m_desc[cfg_addr] = cfg_wdata;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin : compare
    bit act;
    int op, arg;
    if (rst_n && !finished) begin
      act = m_busy && m_cur < 7;
      op  = act ? m_desc[4*m_cur] : 0;
      arg = act ? m_desc[4*m_cur+2] : 0;
      chk("R3 ctl_out", ctl_out, act ? (m_desc[4*m_cur+1] & 8'h3F) : 0);
      chk("R7 addr_out", addr_out, m_addr);
      chk("R8 bus_oe", bus_oe, act && op[1]);
      chk("R8 bus_dout", bus_dout, m_dout);
      chk("R8 wr_ready", wr_ready, act && op[3] && (op[0] || m_tick == arg) && (!op[2] || !m_rdv));
      chk("R9 rd_valid", rd_valid, m_rdv);
      if (m_rdv) begin
        chk("R9 rd_data", rd_data, m_rdd);
        chk("R9 rd_last", rd_last, m_rdl);
      end
      chk("R6 busy", busy, m_busy);
      chk("R6 done", done, m_done);
    end
  end

  // random stimulus on device-side inputs
  always @(negedge clk) begin
    if (rand_en) begin
      #1;
      rdy_in   = 6'($urandom);
      cpu_rdy  = 1'($urandom);
      rd_ready = ($urandom % 3) != 0;
      wr_valid = ($urandom % 4) != 0;
      wr_data  = 16'($urandom);
      bus_din  = 16'($urandom);
      ep_empty = 4'($urandom);
      ep_full  = 4'($urandom);
      ep_prog  = 4'($urandom);
    end
  end

  // ---------------- tasks ----------------
  task automatic set_iv(input int i, input int op, input int outs, input int arg, input int lg);
    int b[4];
    b[0] = op; b[1] = outs; b[2] = arg; b[3] = lg;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      cfg_we = 1'b1; cfg_addr = 5'(4*i + k); cfg_wdata = 8'(b[k]);
    end
    @(negedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 7; i++) set_iv(i, 0, 0, 0, 0);
  endtask

  task automatic start(input int cnt, input int a);
    @(negedge clk); #1;
    go = 1'b1; go_count = 16'(cnt); go_addr = 9'(a);
    @(negedge clk); #1 go = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // decision probe: interval 0 decides, 1 shows 0x11 (true), 2 shows 0x22 (false)
  task automatic probe(input string tag, input int lg, input bit exp_true);
    set_iv(0, 1, 0, 8'h11, lg);
    start(1, 0);
    @(negedge clk);
    chk(tag, ctl_out, exp_true ? 6'h11 : 6'h22);
    wait_idle();
  endtask

  int cnt;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ctl_out", ctl_out, 0);
    chk("R1 addr_out", addr_out, 0);
    chk("R1 rd_valid/wr_ready/bus_oe", {rd_valid, wr_ready, bus_oe}, 0);

    // Program A: delay, delay, decision wait
    set_iv(0, 8'h10, 8'h01, 2, 0);
    set_iv(1, 8'h00, 8'h02, 0, 0);
    set_iv(2, 8'h01, 8'h03, 8'h17, 8'h08);   // AND(rdy0,rdy1): true->7, false->2
    set_iv(7 - 1, 0, 0, 0, 0);
    rdy_in = 6'h03;
    start(3, 9'h100);
    chk("R2 busy after go", busy, 1);
    chk("R2 addr loaded", addr_out, 9'h100);
    chk("R3 hold clk1", ctl_out, 1);
    @(negedge clk); chk("R3 hold clk2", ctl_out, 1);
    @(negedge clk); chk("R3 hold clk3", ctl_out, 1);
    @(negedge clk); chk("R3 next interval", ctl_out, 2);
    // R10: table write while busy is ignored; R2: go while busy ignored
    #1 cfg_we = 1'b1; cfg_addr = 5'd1; cfg_wdata = 8'h3F;
    go = 1'b1; go_addr = 9'h055; go_count = 16'd9;
    @(negedge clk); #1 cfg_we = 1'b0; go = 1'b0;
    chk("R2 go while busy", (addr_out == 9'h055) ? 1 : 0, 0);
    rand_en = 1'b1;
    wait_idle();
    rand_en = 1'b0;
    chk("R6 done after run", done, 1);
    // R10: out-of-range address ignored too
    set_iv(7, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    rdy_in = 6'h03;
    start(1, 0);
    chk("R10 table unchanged", ctl_out, 1);
    wait_idle();

    // R4 and R5: decision sources and functions
    clear_prog();
    set_iv(1, 1, 8'h11, 8'h3F, 0);
    set_iv(2, 1, 8'h22, 8'h3F, 0);
    rdy_in = 6'h01; cpu_rdy = 1'b1;
    probe("R4 AND", {2'd0, 3'd3, 3'd0}, 0);
    probe("R4 OR",  {2'd1, 3'd3, 3'd0}, 1);
    probe("R4 XOR", {2'd2, 3'd3, 3'd0}, 1);
    probe("R4 PASS", {2'd3, 3'd3, 3'd0}, 1);
    rdy_in = 6'h20;
    probe("R4 XOR cpu,rdy5", {2'd2, 3'd5, 3'd7}, 0);
    ep_sel = 2'd2; flag_mode = 8'b00_10_01_11;   // ep2 full, ep1 empty
    ep_full = 4'b0100; ep_empty = 4'b1011; ep_prog = 4'b0000;
    probe("R5 ep2 full", {2'd3, 3'd0, 3'd6}, 1);
    flag_mode = 8'b00_01_10_11;                  // ep2 empty
    probe("R5 ep2 empty", {2'd3, 3'd0, 3'd6}, 0);
    ep_sel = 2'd1;                               // ep1 full flag = 0
    probe("R5 ep1 full", {2'd3, 3'd0, 3'd6}, 0);
    ep_sel = 2'd2; flag_mode = 8'b00_00_10_11; ep_prog = 4'b0100;
    probe("R5 ep2 prog", {2'd3, 3'd0, 3'd6}, 1);
    flag_mode = 8'b00_11_10_11;
    probe("R5 ep2 off", {2'd3, 3'd0, 3'd6}, 0);

    // R8/R7: outbound stream with gaps
    clear_prog();
    set_iv(0, 8'h1A, 8'h04, 1, 0);
    set_iv(1, 8'h01, 8'h05, 8'h07, {2'd3, 3'd0, 3'd2});  // rdy2 ? end : loop
    rand_en = 1'b1;
    start(20, 9'h1F8);
    wait_idle();

    // R9: inbound capture with back-pressure and tail word
    clear_prog();
    set_iv(0, 8'h14, 8'h08, 0, 0);
    set_iv(1, 8'h01, 8'h10, 8'h02, {2'd2, 3'd5, 3'd7});
    set_iv(2, 8'h24, 8'h20, 2, 0);
    start(15, 9'h010);
    wait_idle();
    rand_en = 1'b0;
    rd_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 stream drained", rd_valid, 0);

    // R6: repeat counts 1 and 0 (65536)
    clear_prog();
    set_iv(0, 8'h01, 8'h01, 8'h3F, {2'd3, 3'd0, 3'd0});
    rdy_in = 6'h01;
    start(1, 0);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk("R6 count 1 busy clocks", cnt, 2);
    start(0, 0);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk("R6 count 0 busy clocks", cnt, 131072);
    chk("R6 done held", done, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule